// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32.768 kHz enable strobe into a programmable periodic event. A 4-bit rate code picks a period that is a power of two of the strobe, from 4 strobes (8192 Hz) up to 16384 strobes (2 Hz). Events are tied to a free-running 14-bit strobe counter. An event happens on the strobe that makes the counter's low bits roll over to zero together. Every event therefore lands on a multiple of the period, whenever the code was written.

Each event gives four single-cycle strobes. There is a generic event pulse and a flag-set strobe for a status flag kept elsewhere. An interrupt-set strobe follows when the periodic interrupt enable is on. A square-wave pulse follows when the square-wave output is enabled. A divider-chain hold input clears the strobe counter and stops all events.

Top module: `periodic_rate_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all four outputs are low and the strobe counter is zero.
- R2: A rate code of 0 stops the generator: no output pulses, whatever the enables are.
- R3: For codes 3 to 15, the period is 2^(code-1) strobes. With the strobe high every cycle, code 3 gives 16 events in 64 cycles and code 15 gives 1 event in 16384 cycles.
- R4: Codes 1 and 2 give the same periods as codes 8 and 9: 128 and 256 strobes.
- R5: An event fires on a strobe cycle in which the low (p) bits of the counter are all ones, with the period 2^p. The counter starts at zero after reset or hold and counts strobes modulo 2^14.
- R6: The generator runs only when the periodic interrupt enable or the square-wave enable is set.
- R7: The flag-set strobe comes with every event. The interrupt-set strobe comes only with events in a cycle where the periodic interrupt enable was set.
- R8: When the square-wave enable is set, each event gives exactly one single-cycle pulse on the square-wave output.
- R9: While the divider-chain hold is high, the counter is cleared and no event fires. Counting resumes from zero after the hold is released.
- R10: After a rate-code change, the next event is the next aligned boundary of the new period on the running counter. No extra pulse appears.
- R11: Each output pulse is one clock cycle wide and appears in the cycle after the clock edge that took the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_32k_i | input | 1 | One-cycle enable at the 32.768 kHz rate |
| chain_hold_i | input | 1 | Divider-chain hold: clears the counter and stops events |
| rate_code_i | input | 4 | Rate select. 0 means off, 1-2 are aliased to 8-9, and n gives a period of 2^(n-1) |
| pie_en_i | input | 1 | Periodic interrupt enable |
| sqw_en_i | input | 1 | Square-wave pulse enable |
| evt_o | output | 1 | Periodic event, one cycle |
| flag_set_o | output | 1 | Set strobe for the periodic flag |
| irq_set_o | output | 1 | Set strobe for the interrupt request |
| sqw_pulse_o | output | 1 | Square-wave output pulse |

## Verification
The bench builds the block with its default parameters: a 14-bit counter, a 4-bit code, and aliasing of codes 1 and 2 by +7. This makes the longest period (code 15, a full counter wrap) reachable in one directed window. The aliased codes are checked against their 128- and 256-strobe periods. Random runs with sparse strobes, enable changes and code switches in mid-period exercise alignment across changes. Short holds test that counting restarts from zero.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

    // Log2 of the period for a code; -1 when the code switches the generator off.
    function automatic int rpg_period_log2(input int code, input int alias_max,
                                           input int alias_add, input int cnt_w);
        int eff;
        int lg;
        if (code == 0) begin
            return -1;
        end
        eff = (code <= alias_max) ? code + alias_add : code;
        lg  = eff - 1;
        if (lg > cnt_w) begin
            lg = cnt_w;
        end
        return lg;
    endfunction

endpackage

// File: rtl/rpg_prescale.sv
module rpg_prescale #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             hold_i,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    // R9
    hold_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (cnt_o == '0));

    // R5
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !tick_i) |=> $stable(cnt_o));

endmodule

// File: rtl/rpg_rate_decode.sv
module rpg_rate_decode #(
    parameter int CNT_W     = 14,
    parameter int CODE_W    = 4,
    parameter int ALIAS_MAX = 2,
    parameter int ALIAS_ADD = 7
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              pie_i,
    input  logic              sqwe_i,
    input  logic              hold_i,
    output logic              run_o,
    output logic [CNT_W-1:0]  mask_o
);
    import rpg_pkg::*;

    localparam int EXP_W = $clog2(CNT_W + 1);

    logic [EXP_W-1:0] lg_c;
    logic             on_c;

    always_comb begin
        int lg;
        lg   = rpg_period_log2(int'(code_i), ALIAS_MAX, ALIAS_ADD, CNT_W);
        on_c = (lg >= 0);
        lg_c = on_c ? EXP_W'(lg) : '0;
    end

    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign mask_o[i] = (lg_c > EXP_W'(i));
    end

    assign run_o = on_c && (pie_i || sqwe_i) && !hold_i;

endmodule

// File: rtl/rpg_event.sv
module rpg_event #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             pie_i,
    input  logic             sqwe_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] mask_i,
    output logic             evt_o,
    output logic             flag_o,
    output logic             irq_o,
    output logic             sq_o
);

    typedef struct packed {
        logic evt;
        logic flag;
        logic irq;
        logic sq;
    } ev_t;

    ev_t  st_d, st_q;
    logic fire_c;

    always_comb begin
        fire_c    = tick_i && run_i && ((cnt_i & mask_i) == mask_i);
        st_d.evt  = fire_c;
        st_d.flag = fire_c;
        st_d.irq  = fire_c && pie_i;
        st_d.sq   = fire_c && sqwe_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o  = st_q.evt;
    assign flag_o = st_q.flag;
    assign irq_o  = st_q.irq;
    assign sq_o   = st_q.sq;

    // R5
    aligned_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> ((cnt_i & $past(mask_i)) == '0));

    // R11
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> $past(tick_i));

    // R11
    single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o);

endmodule

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen #(
    parameter int CNT_W     = 14,
    parameter int CODE_W    = 4,
    parameter int ALIAS_MAX = 2,
    parameter int ALIAS_ADD = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_32k_i,
    input  logic              chain_hold_i,
    input  logic [CODE_W-1:0] rate_code_i,
    input  logic              pie_en_i,
    input  logic              sqw_en_i,
    output logic              evt_o,
    output logic              flag_set_o,
    output logic              irq_set_o,
    output logic              sqw_pulse_o
);

    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] mask_w;
    logic             run_w;

    rpg_prescale #(.CNT_W(CNT_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (strobe_32k_i),
        .hold_i (chain_hold_i),
        .cnt_o  (cnt_w)
    );

    rpg_rate_decode #(
        .CNT_W     (CNT_W),
        .CODE_W    (CODE_W),
        .ALIAS_MAX (ALIAS_MAX),
        .ALIAS_ADD (ALIAS_ADD)
    ) u_dec (
        .code_i (rate_code_i),
        .pie_i  (pie_en_i),
        .sqwe_i (sqw_en_i),
        .hold_i (chain_hold_i),
        .run_o  (run_w),
        .mask_o (mask_w)
    );

    rpg_event #(.CNT_W(CNT_W)) u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (strobe_32k_i),
        .run_i  (run_w),
        .pie_i  (pie_en_i),
        .sqwe_i (sqw_en_i),
        .cnt_i  (cnt_w),
        .mask_i (mask_w),
        .evt_o  (evt_o),
        .flag_o (flag_set_o),
        .irq_o  (irq_set_o),
        .sq_o   (sqw_pulse_o)
    );

    // R2
    code_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rate_code_i) == '0) |-> !evt_o);

    // R6
    enables_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(pie_en_i) && !$past(sqw_en_i)) |-> !evt_o);

    // R7
    irq_follows_pie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> (irq_set_o == $past(pie_en_i)) && flag_set_o);

    // R8
    sq_follows_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sqw_pulse_o |-> (evt_o && $past(sqw_en_i)));

    // R9
    hold_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chain_hold_i) |-> !evt_o);

endmodule

// File: tb/periodic_rate_gen_tb.sv
module periodic_rate_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CNTW       = 14;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick, hold, pie, sqwe;
    logic [3:0] code;
    logic       evt, flg, irq, sqp;

    int  checks = 0;
    int  fails  = 0;
    int  m_cnt  = 0;
    int  ev_seen = 0;
    bit  e_evt, e_flg, e_irq, e_sq;
    bit  done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    periodic_rate_gen u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_32k_i (tick),
        .chain_hold_i (hold),
        .rate_code_i  (code),
        .pie_en_i     (pie),
        .sqw_en_i     (sqwe),
        .evt_o        (evt),
        .flag_set_o   (flg),
        .irq_set_o    (irq),
        .sqw_pulse_o  (sqp)
    );

    function automatic int lg_of(input int c);
        if (c == 0) return -1;
        if (c == 1) return 7;   // same as code 8
        if (c == 2) return 8;   // same as code 9
        return c - 1;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, expv, $time);
        end
    endtask

    // Inputs are already applied at a falling edge; predict, then sample at the next falling edge.
    task automatic cycle(input string tag);
        int  lg;
        int  mask;
        bit  run;
        bit  fire;
        lg   = lg_of(int'(code));
        run  = (lg >= 0) && (pie || sqwe) && !hold;
        mask = (lg > 0) ? ((1 << lg) - 1) : 0;
        fire = tick && run && ((m_cnt & mask) == mask);
        e_evt = fire;
        e_flg = fire;
        e_irq = fire && pie;
        e_sq  = fire && sqwe;
        if (hold) m_cnt = 0;
        else if (tick) m_cnt = (m_cnt + 1) % (1 << CNTW);
        @(negedge clk);
        chk(tag, "evt", int'(evt), int'(e_evt));
        chk(tag, "flag_set", int'(flg), int'(e_flg));
        chk(tag, "irq_set", int'(irq), int'(e_irq));
        chk(tag, "sqw_pulse", int'(sqp), int'(e_sq));
        if (evt) ev_seen++;
    endtask

    task automatic zero_count();
        hold = 1'b1; tick = 1'b0;
        cycle("R9");
        hold = 1'b0;
    endtask

    task automatic window(input logic [3:0] c, input int n, input int expect_ev, input string tag);
        zero_count();
        code = c; pie = 1'b1; sqwe = 1'b0; tick = 1'b1;
        ev_seen = 0;
        for (int i = 0; i < n; i++) cycle(tag);
        chk(tag, "event count", ev_seen, expect_ev);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; tick = 1'b1; hold = 1'b0; pie = 1'b1; sqwe = 1'b1; code = 4'd3;
        repeat (4) @(negedge clk);
        // R1: outputs quiet during reset
        chk("R1", "evt in reset", int'(evt), 0);
        chk("R1", "irq in reset", int'(irq), 0);
        rst_n = 1'b1; tick = 1'b0; m_cnt = 0;
        cycle("R1");

        // R3 / R11: fastest rate, strobe every cycle
        window(4'd3, 64, 16, "R3");
        window(4'd4, 64, 8, "R11");
        window(4'd15, 16384, 1, "R3");
        // R4: aliased codes
        window(4'd1, 256, 2, "R4");
        window(4'd2, 512, 2, "R4");
        window(4'd9, 512, 2, "R4");

        // R2: code 0 silent
        window(4'd0, 300, 0, "R2");

        // R6: no enables, generator stopped
        zero_count();
        code = 4'd3; pie = 1'b0; sqwe = 1'b0; tick = 1'b1; ev_seen = 0;
        for (int i = 0; i < 100; i++) cycle("R6");
        chk("R6", "event count", ev_seen, 0);

        // R7 / R8: square-wave only, then interrupt only
        zero_count();
        code = 4'd5; pie = 1'b0; sqwe = 1'b1; tick = 1'b1;
        for (int i = 0; i < 80; i++) cycle("R8");
        pie = 1'b1; sqwe = 1'b0;
        for (int i = 0; i < 80; i++) cycle("R7");

        // R9: hold held for a while with strobes running
        hold = 1'b1; ev_seen = 0;
        for (int i = 0; i < 40; i++) cycle("R9");
        chk("R9", "events under hold", ev_seen, 0);
        hold = 1'b0;
        for (int i = 0; i < 40; i++) cycle("R9");

        // R10: switch codes in mid-period
        code = 4'd10; sqwe = 1'b1;
        for (int i = 0; i < 300; i++) cycle("R10");
        code = 4'd3;
        for (int i = 0; i < 20; i++) cycle("R10");
        code = 4'd7;
        for (int i = 0; i < 200; i++) cycle("R10");

        // R5: random strobes, enables and code changes
        for (int i = 0; i < 30000; i++) begin
            tick = (($urandom % 4) != 0);
            if (($urandom % 400) == 0) begin
                code = 4'($urandom % 16);
                pie  = 1'($urandom % 2);
                sqwe = 1'($urandom % 2);
            end
            hold = (($urandom % 3000) == 0);
            cycle("R5");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule